// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the parity lines of a 64-bit multiplexed address/data bus. The bus carries address and data on one set of lines. A node on it can take part in a transfer either as the initiator or as the target. Every clock, the block forms even parity over each 32-bit half of the bus together with that half's four command/byte-enable bits. One clock later it either puts that parity on the bus or compares it with the parity that another agent has put there.

The block decides for itself which of the two it does. It looks at the phase type, the node's role, the transfer direction and whether the transfer uses the full 64-bit width. The side that drove the address or data also drives its parity. The receiving side checks the parity, but only on data phases that complete. A mismatch produces a one-clock, active-low error pulse. That pulse appears two clocks after the faulty data phase and only while error response is enabled. The block drives the error line high for one more clock before it releases the line.

The bus is a shared, clock-synchronous bus with no back-pressure of its own, so the block has no valid/ready handshake. Every input is sampled on each rising edge, and every output is a plain registered level.

Top module: `pbus_parity_unit`

## Requirements
- R1: In every clock after reset, `par_out` equals the XOR of all 36 bits `ad[31:0]` and `cbe[3:0]` as sampled at the previous rising edge. All four byte-enable bits count, whatever their values.
- R2: In every clock after reset, `par64_out` equals the XOR of `ad[63:32]` and `cbe[7:4]` as sampled at the previous rising edge.
- R3: The `bus_phase` encoding is 0 for idle, 1 for address, 2 for data and 3 for turnaround. After an address phase in which `is_initiator` is 1, `par_oe` is 1 in the following clock.
- R4: After a data phase (`bus_phase`=2), `par_oe` is 1 in the following clock when the node is initiator of a write or target of a read. After any other clock, `par_oe` is 0. This includes data phases of initiator reads and target writes, target address phases, idle clocks and turnaround clocks.
- R5: `par64_oe` is 1 in the clock after a data phase that sets `par_oe` and also has `wide64`=1. In every other clock it is 0, which includes every clock after an address phase.
- R6: A data phase is checked when it completes (`irdy`=1 and `trdy`=1) and the node is initiator of a read or target of a write. If `par_in` in the next clock differs from R1's parity of that phase, and `perr_en` is 1 in that same next clock, then `perr_n` is 0 for exactly the clock two clocks after the data phase.
- R7: A mismatch on `par64_in` counts as an error under R6 only when `wide64` was 1 in the checked data phase.
- R8: `perr_n` stays 1 in each of these cases: the clock after one with `perr_en`=0; after data phases that do not complete; after data phases in which this node drove the data.
- R9: `perr_oe` is 1 in every clock where `perr_n` is 0 and in the clock after such a clock. In every other clock it is 0.
- R10: While `rst_n` is 0, `par_oe`, `par64_oe` and `perr_oe` are 0 and `perr_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_phase | input | 2 | Phase type: 0 idle, 1 address, 2 data, 3 turnaround |
| is_initiator | input | 1 | 1 when this node is the initiator of the current transfer |
| is_write | input | 1 | 1 when the current transfer is a write |
| irdy | input | 1 | Initiator ready (active high) |
| trdy | input | 1 | Target ready (active high) |
| wide64 | input | 1 | Both sides agreed to a 64-bit transfer |
| perr_en | input | 1 | Parity error response enable |
| ad | input | 64 | Address/data lines as seen on the bus |
| cbe | input | 8 | Command/byte-enable lines as seen on the bus (raw levels) |
| par_in | input | 1 | Low-half parity line as seen on the bus |
| par64_in | input | 1 | High-half parity line as seen on the bus |
| par_out | output | 1 | Generated low-half parity |
| par_oe | output | 1 | Output enable for `par_out` |
| par64_out | output | 1 | Generated high-half parity |
| par64_oe | output | 1 | Output enable for `par64_out` |
| perr_n | output | 1 | Parity error, active low |
| perr_oe | output | 1 | Output enable for `perr_n` |

## Verification
The generated parity lines and their enables are due one clock after the address or data phase they cover. An error pulse is due two clocks after the checked data phase. It is gated by the enable seen one clock after that phase, and its output enable stays up for a further clock. The bench applies inputs on the falling edge and advances a behavioural model at each rising edge. On the next falling edge it compares all six outputs with that model, so each result is checked in exactly the clock it is due. Directed phases cover each role and direction, each kind of mismatch and each suppression case, and are followed by a long randomized run.

// File: rtl/pbus_parity_pkg.sv
package pbus_parity_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_TURN = 2'd3
  } bus_phase_e;

  // A data-phase direction in which this node receives and must check.
  function automatic logic node_receives(input logic initiator, input logic write);
    return initiator ^ write;
  endfunction

endpackage

// File: rtl/pbus_lane_parity.sv
module pbus_lane_parity #(
  parameter int LANE_W = 32,
  parameter int BE_W   = 4,
  parameter int LANES  = 2
) (
  input  logic [LANES*LANE_W-1:0] ad,
  input  logic [LANES*BE_W-1:0]   cbe,
  output logic [LANES-1:0]        lane_par
);

  // Even parity per lane: XOR over the lane's data bits and its byte enables.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W+BE_W-1:0] lane_bits;
    assign lane_bits   = {cbe[l*BE_W +: BE_W], ad[l*LANE_W +: LANE_W]};
    assign lane_par[l] = ^lane_bits;
  end

endmodule

// File: rtl/pbus_drive_ctl.sv
module pbus_drive_ctl
  import pbus_parity_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_phase_e       phase,
  input  logic             initiator,
  input  logic             write,
  input  logic             wide64,
  input  logic [LANES-1:0] lane_par,
  output logic [LANES-1:0] par_q,
  output logic [LANES-1:0] oe_q
);

  logic drive_now;
  logic [LANES-1:0] oe_next;

  // The node drives whatever it drove on AD: addresses as initiator, data
  // when it is the sender of the data phase.
  always_comb begin
    drive_now = 1'b0;
    unique case (phase)
      PH_ADDR: drive_now = initiator;
      PH_DATA: drive_now = !node_receives(initiator, write);
      default: drive_now = 1'b0;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_oe
    if (l == 0) begin : g_base
      assign oe_next[l] = drive_now;
    end else begin : g_ext
      assign oe_next[l] = drive_now && (phase == PH_DATA) && wide64;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q <= '0;
      oe_q  <= '0;
    end else begin
      par_q <= lane_par;
      oe_q  <= oe_next;
    end
  end

  p_addr_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && initiator) |=> oe_q[0]);

  p_no_drive_on_receive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && node_receives(initiator, write)) |=> !oe_q[0]);

  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_TURN) |=> (oe_q == '0));

  p_ext_inside_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q[LANES-1] |-> oe_q[0]);

endmodule

// File: rtl/pbus_check.sv
module pbus_check
  import pbus_parity_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_phase_e       phase,
  input  logic             initiator,
  input  logic             write,
  input  logic             irdy,
  input  logic             trdy,
  input  logic             wide64,
  input  logic             perr_en,
  input  logic [LANES-1:0] lane_par,
  input  logic [LANES-1:0] par_in,
  output logic             perr_n,
  output logic             perr_oe
);

  logic             take;
  logic [LANES-1:0] chk_q;
  logic [LANES-1:0] exp_q;
  logic             mism;
  logic             perr_q;
  logic             perr_d;

  assign take = (phase == PH_DATA) && irdy && trdy && node_receives(initiator, write);

  // Stage 1: latch expected parity and which lanes count.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_q <= '0;
      exp_q <= '0;
    end else begin
      exp_q <= lane_par;
      for (int l = 0; l < LANES; l++) begin
        chk_q[l] <= take && ((l == 0) || wide64);
      end
    end
  end

  // Compare against the parity that arrives one clock after the data.
  assign mism = |(chk_q & (exp_q ^ par_in));

  // Stage 2: error pulse, then one clock of driving high before release.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      perr_d <= 1'b0;
    end else begin
      perr_q <= mism && perr_en;
      perr_d <= perr_q;
    end
  end

  assign perr_n  = !perr_q;
  assign perr_oe = perr_q || perr_d;

  p_perr_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(take, 2));

  p_perr_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_en |=> perr_n);

  p_perr_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> perr_oe);

  p_perr_trail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |=> perr_oe);

endmodule

// File: rtl/pbus_parity_unit.sv
module pbus_parity_unit
  import pbus_parity_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int BE_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_phase,
  input  logic                is_initiator,
  input  logic                is_write,
  input  logic                irdy,
  input  logic                trdy,
  input  logic                wide64,
  input  logic                perr_en,
  input  logic [2*LANE_W-1:0] ad,
  input  logic [2*BE_W-1:0]   cbe,
  input  logic                par_in,
  input  logic                par64_in,
  output logic                par_out,
  output logic                par_oe,
  output logic                par64_out,
  output logic                par64_oe,
  output logic                perr_n,
  output logic                perr_oe
);

  localparam int LANES = 2;

  bus_phase_e       phase;
  logic [LANES-1:0] lane_par;
  logic [LANES-1:0] par_q;
  logic [LANES-1:0] oe_q;

  assign phase = bus_phase_e'(bus_phase);

  pbus_lane_parity #(.LANE_W(LANE_W), .BE_W(BE_W), .LANES(LANES)) u_par (
    .ad       (ad),
    .cbe      (cbe),
    .lane_par (lane_par)
  );

  pbus_drive_ctl #(.LANES(LANES)) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .initiator (is_initiator),
    .write     (is_write),
    .wide64    (wide64),
    .lane_par  (lane_par),
    .par_q     (par_q),
    .oe_q      (oe_q)
  );

  pbus_check #(.LANES(LANES)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .initiator (is_initiator),
    .write     (is_write),
    .irdy      (irdy),
    .trdy      (trdy),
    .wide64    (wide64),
    .perr_en   (perr_en),
    .lane_par  (lane_par),
    .par_in    ({par64_in, par_in}),
    .perr_n    (perr_n),
    .perr_oe   (perr_oe)
  );

  assign par_out   = par_q[0];
  assign par64_out = par_q[1];
  assign par_oe    = oe_q[0];
  assign par64_oe  = oe_q[1];

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> (!par_oe && !par64_oe && !perr_oe && perr_n));

endmodule

// File: tb/pbus_parity_unit_tb.sv
module pbus_parity_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_phase = 2'd0;
  logic        is_initiator = 1'b0, is_write = 1'b0, irdy = 1'b0, trdy = 1'b0;
  logic        wide64 = 1'b0, perr_en = 1'b0;
  logic [63:0] ad = '0;
  logic [7:0]  cbe = '0;
  logic        par_in = 1'b0, par64_in = 1'b0;
  logic        par_out, par_oe, par64_out, par64_oe, perr_n, perr_oe;

  always #2.5 clk = ~clk;

  pbus_parity_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .is_initiator(is_initiator),
    .is_write(is_write), .irdy(irdy), .trdy(trdy), .wide64(wide64), .perr_en(perr_en),
    .ad(ad), .cbe(cbe), .par_in(par_in), .par64_in(par64_in),
    .par_out(par_out), .par_oe(par_oe), .par64_out(par64_out), .par64_oe(par64_oe),
    .perr_n(perr_n), .perr_oe(perr_oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural model state
  bit m_par, m_par64, m_oe, m_oe64, m_perr, m_perr_d;
  bit m_exp_lo, m_exp_hi, m_chk_lo, m_chk_hi;
  bit prev_lo, prev_hi;   // bench's own parity of the previous clock's data

  function automatic bit odd(input logic [35:0] v);
    return ($countones(v) % 2) == 1;
  endfunction

  task automatic expect_bit(input string req, input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    expect_bit("R1", "par_out",   par_out,   m_par);
    expect_bit("R2", "par64_out", par64_out, m_par64);
    expect_bit("R4", "par_oe",    par_oe,    m_oe);
    expect_bit("R5", "par64_oe",  par64_oe,  m_oe64);
    expect_bit("R6", "perr_n",    perr_n,    !m_perr);
    expect_bit("R9", "perr_oe",   perr_oe,   m_perr || m_perr_d);
  endtask

  // One bus clock. Entered and left on a falling edge.
  // bad_lo / bad_hi corrupt the parity returned for the previous clock's data.
  task automatic cyc(input logic [1:0] ph, input bit init, input bit wr, input bit ir,
                     input bit tr, input bit w64, input bit en, input logic [63:0] d,
                     input logic [7:0] be, input bit bad_lo, input bit bad_hi);
    bit recv, take, err, cur_lo, cur_hi, drive;
    bus_phase = ph; is_initiator = init; is_write = wr; irdy = ir; trdy = tr;
    wide64 = w64; perr_en = en; ad = d; cbe = be;
    par_in   = prev_lo ^ bad_lo;
    par64_in = prev_hi ^ bad_hi;
    cur_lo = odd({be[3:0], d[31:0]});
    cur_hi = odd({be[7:4], d[63:32]});
    @(posedge clk);
    recv  = (init && !wr) || (!init && wr);
    take  = (ph == 2'd2) && ir && tr && recv;
    drive = (ph == 2'd1 && init) || (ph == 2'd2 && !recv);
    err = (m_chk_lo && (par_in != m_exp_lo)) || (m_chk_hi && (par64_in != m_exp_hi));
    m_perr_d = m_perr;
    m_perr   = err && en;
    m_exp_lo = cur_lo; m_exp_hi = cur_hi;
    m_chk_lo = take;   m_chk_hi = take && w64;
    m_par = cur_lo; m_par64 = cur_hi;
    m_oe  = drive;  m_oe64 = drive && (ph == 2'd2) && w64;
    prev_lo = cur_lo; prev_hi = cur_hi;
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R10: reset state, with inputs that would otherwise drive.
    bus_phase = 2'd1; is_initiator = 1'b1; perr_en = 1'b1;
    repeat (3) @(negedge clk);
    expect_bit("R10", "par_oe",   par_oe,   1'b0);
    expect_bit("R10", "par64_oe", par64_oe, 1'b0);
    expect_bit("R10", "perr_oe",  perr_oe,  1'b0);
    expect_bit("R10", "perr_n",   perr_n,   1'b1);
    rst_n = 1'b1;
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);

    // R3, R1, R2: initiator write, address then wide data with disabled lanes (R1).
    cyc(2'd1, 1, 1, 0, 0, 1, 1, 64'h0000_0000_1234_5678, 8'h07, 0, 0);
    cyc(2'd2, 1, 1, 1, 0, 1, 1, 64'hDEAD_BEEF_0F0F_0001, 8'hFF, 0, 0);
    cyc(2'd2, 1, 1, 1, 1, 1, 1, 64'h8000_0001_FFFF_FFFF, 8'h00, 0, 0);
    cyc(2'd3, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);
    // R4: target read drives data parity; target address phase does not.
    cyc(2'd1, 0, 0, 0, 0, 0, 1, 64'h1111_2222_3333_4444, 8'h06, 0, 0);
    cyc(2'd2, 0, 0, 1, 1, 0, 1, 64'hCAFE_F00D_0000_0003, 8'hF0, 0, 0);
    cyc(2'd3, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);
    // R6: initiator read, good parity then bad low parity.
    cyc(2'd2, 1, 0, 1, 1, 0, 1, 64'h0000_0000_AAAA_5555, 8'h00, 0, 0);
    cyc(2'd2, 1, 0, 1, 1, 0, 1, 64'h0000_0000_0000_0007, 8'h00, 0, 0);
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 1, 0);   // bad PAR for previous phase
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);   // perr_n low here
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);   // R9 trailing drive
    // R7: bad PAR64 on wide target write -> error; on narrow -> none.
    cyc(2'd2, 0, 1, 1, 1, 1, 1, 64'h1357_9BDF_2468_ACE0, 8'h3C, 0, 0);
    cyc(2'd2, 0, 1, 1, 1, 0, 1, 64'h1357_9BDF_2468_ACE0, 8'h3C, 0, 1);
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 1);
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);
    // R8: wait state, disabled response, and own-driven data all stay quiet.
    cyc(2'd2, 1, 0, 1, 0, 0, 1, 64'h0000_0000_0000_00FF, 8'h00, 0, 0);
    cyc(2'd2, 1, 0, 1, 1, 0, 1, 64'h0000_0000_0000_00FE, 8'h00, 1, 0);
    cyc(2'd0, 0, 0, 0, 0, 0, 0, 64'h0, 8'h0, 1, 0);
    cyc(2'd2, 1, 1, 1, 1, 0, 1, 64'h0000_0000_0000_0011, 8'h00, 0, 0);
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 1, 1);
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);
    // R6/R9: back-to-back errors on consecutive completed phases.
    cyc(2'd2, 0, 1, 1, 1, 1, 1, 64'h0F0F_0F0F_F0F0_F0F0, 8'h81, 0, 0);
    cyc(2'd2, 0, 1, 1, 1, 1, 1, 64'h0000_0001_0000_0001, 8'h11, 1, 0);
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 1);
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);
    cyc(2'd0, 0, 0, 0, 0, 0, 1, 64'h0, 8'h0, 0, 0);

    // Randomized traffic across all phases, roles and error injections.
    for (int i = 0; i < 3000; i++) begin
      cyc($urandom_range(3, 0), $urandom_range(1, 0), $urandom_range(1, 0),
          $urandom_range(3, 0) != 0, $urandom_range(3, 0) != 0, $urandom_range(1, 0),
          $urandom_range(7, 0) != 0, {$urandom, $urandom}, 8'($urandom),
          $urandom_range(5, 0) == 0, $urandom_range(5, 0) == 0);
    end
    summary();
  end

endmodule